// File: doc/BRIEF.md
# Character Display Instruction Decoder

This block models the device side of a character display controller's instruction logic. A host drives one transaction per strobe. Each transaction carries a select bit (command or data), a read bit and one byte. The block keeps an address counter, a choice between a 128-byte text RAM and a 64-byte glyph RAM, the entry-mode bits, the display, cursor and blink bits, the function bits and a horizontal display-shift offset. It answers status reads and data reads.

The address counter follows the display geometry. In two-line mode the text addresses run 0x00-0x27 on the upper line and 0x40-0x67 on the lower line. In one-line mode they run 0x00-0x4F. The counter wraps both ways. Data reads pass through an output register, so a read that follows a write returns the value that register last held. Every accepted instruction holds a busy flag for a set number of cycles. Any transaction other than a status read that arrives while busy is refused and flagged.

Top module: `lcd_instr_core`

## Requirements
- R1: After reset: address counter 0, text RAM selected, increment direction, no auto shift, `disp_o`=0, `func_o`=3'b100, `shift_o`=0, `busy_o`=0, `err_o`=0, `rdata_o`=0. Every text byte reads 0x20 and every glyph byte reads 0x00.
- R2: A command (`sel_i`=0, `rd_i`=0) is decoded by its highest set bit. If 0x08 is the highest set bit, bits 2..0 load `disp_o` {display, cursor, blink}. If 0x20 is the highest set bit, bits 4..2 load `func_o` {bus8, two_line, tall_font}.
- R3: Command 0x01 fills the text RAM with 0x20. It also sets the address counter to 0, selects text RAM, forces the increment direction and sets `shift_o` to 0.
- R4: A command whose highest set bit is 0x02 sets the address counter and `shift_o` to 0 and selects text RAM. Text RAM contents stay as they were.
- R5: Command 0x80|a loads the 7-bit text address a. Command 0x40|a loads the 6-bit glyph address a. The most recent of the two picks the RAM used by data transfers. A status read (`sel_i`=0, `rd_i`=1) returns {busy, address counter} in `rdata_o` on the next cycle.
- R6: Command 0x04|(id<<1)|sh sets the direction bit id and the auto-shift bit sh. Each data write (`sel_i`=1, `rd_i`=0) and each data read (`sel_i`=1, `rd_i`=1) steps the address counter by one: up when id=1, down when id=0.
- R7: In two-line text mode, stepping up goes 0x27 to 0x40 and 0x67 to 0x00. Stepping down goes 0x40 to 0x27 and 0x00 to 0x67.
- R8: In one-line text mode, stepping goes 0x4F to 0x00 going up and 0x00 to 0x4F going down. Glyph addresses wrap within 6 bits.
- R9: Command 0x10|(sc<<3)|(rl<<2) acts as follows. sc=0 steps the address counter: down when rl=0, up when rl=1. sc=1 changes `shift_o` by +1 when rl=0 (left) or by -1 when rl=1 (right), modulo 40 in two-line mode and modulo 80 in one-line mode, and leaves the address counter unchanged.
- R10: A text-RAM data write with sh=1 changes `shift_o` by +1 when id=1 and by -1 when id=0. Glyph writes and all data reads leave `shift_o` unchanged.
- R11: A data read returns the output register. That register is loaded from RAM at the new address by an address set, by a cursor step, and after each data read. Data writes do not load it.
- R12: Every accepted transaction except a status read holds `busy_o` high for exactly BUSY_CYC cycles. A transaction other than a status read that arrives while busy is ignored and pulses `err_o` on the next cycle. A status read while busy returns bit 7 set and raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transaction strobe, one per cycle |
| sel_i | input | 1 | 0 = command or status, 1 = RAM data |
| rd_i | input | 1 | 1 = read, 0 = write |
| wdata_i | input | 8 | Command or data byte |
| rdata_o | output | 8 | Read result, registered |
| busy_o | output | 1 | Instruction in progress |
| err_o | output | 1 | One-cycle pulse after a refused transaction |
| disp_o | output | 3 | {display, cursor, blink} |
| func_o | output | 3 | {bus8, two_line, tall_font} |
| shift_o | output | 7 | Display shift offset |

## Verification
The bench builds the block with BUSY_CYC=3 and keeps the 40-character line length and the 0x40 base for the second line. This keeps each instruction short enough to issue a back-to-back transaction that is refused and a status read that lands inside the busy window, and to count the busy cycles exactly. It also exercises every wrap point of both line modes (0x27, 0x40, 0x4F, 0x67), the 6-bit glyph wrap, and the shift offset wrapping at 40.

// File: rtl/lcd_core_pkg.sv
package lcd_core_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_TADDR,
    OP_GADDR,
    OP_FUNC,
    OP_SHIFT,
    OP_DISP,
    OP_ENTRY,
    OP_HOME,
    OP_CLEAR
  } lcd_op_e;

  // highest set bit picks the instruction
  function automatic lcd_op_e lcd_decode(input logic [7:0] b);
    lcd_op_e op;
    casez (b)
      8'b1???????: op = OP_TADDR;
      8'b01??????: op = OP_GADDR;
      8'b001?????: op = OP_FUNC;
      8'b0001????: op = OP_SHIFT;
      8'b00001???: op = OP_DISP;
      8'b000001??: op = OP_ENTRY;
      8'b0000001?: op = OP_HOME;
      8'b00000001: op = OP_CLEAR;
      default:     op = OP_NONE;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/lcd_addr_step.sv
module lcd_addr_step #(
  parameter int AW         = 7,
  parameter int GAW        = 6,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64
) (
  input  logic [AW-1:0] ac_i,
  input  logic          up_i,
  input  logic          two_line_i,
  input  logic          glyph_i,
  output logic [AW-1:0] nxt_o
);
  localparam logic [AW-1:0] L1_LAST  = AW'(LINE_LEN - 1);
  localparam logic [AW-1:0] L2_BASE  = AW'(LINE2_BASE);
  localparam logic [AW-1:0] L2_LAST  = AW'(LINE2_BASE + LINE_LEN - 1);
  localparam logic [AW-1:0] ONE_LAST = AW'(2 * LINE_LEN - 1);

  logic [GAW-1:0] g_nxt;

  always_comb begin
    g_nxt = up_i ? ac_i[GAW-1:0] + GAW'(1) : ac_i[GAW-1:0] - GAW'(1);
    if (glyph_i) begin
      nxt_o = {{(AW-GAW){1'b0}}, g_nxt};
    end else if (two_line_i) begin
      if (up_i) begin
        if (ac_i == L1_LAST)      nxt_o = L2_BASE;
        else if (ac_i >= L2_LAST) nxt_o = '0;
        else                      nxt_o = ac_i + AW'(1);
      end else begin
        if (ac_i == L2_BASE)      nxt_o = L1_LAST;
        else if (ac_i == '0)      nxt_o = L2_LAST;
        else                      nxt_o = ac_i - AW'(1);
      end
    end else begin
      if (up_i) nxt_o = (ac_i >= ONE_LAST) ? '0 : ac_i + AW'(1);
      else      nxt_o = (ac_i == '0) ? ONE_LAST : ac_i - AW'(1);
    end
  end
endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
  parameter int CYC = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= CW'(CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/lcd_char_store.sv
module lcd_char_store #(
  parameter int          AW   = 7,
  parameter int          GAW  = 6,
  parameter int          DW   = 8,
  parameter logic [7:0]  FILL = 8'h20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          wglyph_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clear_i,
  input  logic          rglyph_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int TDEPTH = 2 ** AW;
  localparam int GDEPTH = 2 ** GAW;

  logic [DW-1:0] text_q  [TDEPTH];
  logic [DW-1:0] glyph_q [GDEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TDEPTH; i++) text_q[i] <= DW'(FILL);
    end else if (clear_i) begin
      for (int i = 0; i < TDEPTH; i++) text_q[i] <= DW'(FILL);
    end else if (we_i && !wglyph_i) begin
      text_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < GDEPTH; i++) glyph_q[i] <= '0;
    end else if (we_i && wglyph_i) begin
      glyph_q[waddr_i[GAW-1:0]] <= wdata_i;
    end
  end

  assign rdata_o = rglyph_i ? glyph_q[raddr_i[GAW-1:0]] : text_q[raddr_i];
endmodule

// File: rtl/lcd_instr_core.sv
module lcd_instr_core
  import lcd_core_pkg::*;
#(
  parameter int BUSY_CYC   = 40,
  parameter int TEXT_AW    = 7,
  parameter int GLYPH_AW   = 6,
  parameter int DW         = 8,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64,
  parameter int SW         = $clog2(2 * LINE_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          sel_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o,
  output logic          err_o,
  output logic [2:0]    disp_o,
  output logic [2:0]    func_o,
  output logic [SW-1:0] shift_o
);
  localparam logic [SW-1:0] LAST_TWO = SW'(LINE_LEN - 1);
  localparam logic [SW-1:0] LAST_ONE = SW'(2 * LINE_LEN - 1);

  logic [TEXT_AW-1:0] ac_q, ac_nxt, rd_addr;
  logic               glyph_q, id_q, sh_q, rd_glyph;
  logic [DW-1:0]      out_q, ram_rd, status_word;
  logic               status_rd, accept, reject, cmd, dwr, drd, step_up;
  lcd_op_e            op;

  function automatic logic [SW-1:0] shift_step(input logic [SW-1:0] cur,
                                               input logic left,
                                               input logic two);
    logic [SW-1:0] last;
    last = two ? LAST_TWO : LAST_ONE;
    if (left) return (cur >= last) ? '0 : cur + SW'(1);
    return (cur == '0 || cur > last) ? last : cur - SW'(1);
  endfunction

  assign status_rd = req_i && !sel_i && rd_i;
  assign accept    = req_i && !busy_o && !status_rd;
  assign reject    = req_i && busy_o && !status_rd;
  assign cmd       = accept && !sel_i && !rd_i;
  assign dwr       = accept && sel_i && !rd_i;
  assign drd       = accept && sel_i && rd_i;
  assign op        = lcd_decode(wdata_i[7:0]);
  assign step_up   = cmd ? wdata_i[2] : id_q;

  lcd_addr_step #(
    .AW(TEXT_AW), .GAW(GLYPH_AW), .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE)
  ) u_step (
    .ac_i(ac_q), .up_i(step_up), .two_line_i(func_o[1]), .glyph_i(glyph_q),
    .nxt_o(ac_nxt)
  );

  lcd_busy_timer #(.CYC(BUSY_CYC)) u_busy (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept), .busy_o(busy_o)
  );

  // read port follows the address the output register will reload from
  always_comb begin
    rd_addr  = ac_nxt;
    rd_glyph = glyph_q;
    if (cmd && op == OP_TADDR) begin
      rd_addr  = wdata_i[TEXT_AW-1:0];
      rd_glyph = 1'b0;
    end else if (cmd && op == OP_GADDR) begin
      rd_addr  = {{(TEXT_AW-GLYPH_AW){1'b0}}, wdata_i[GLYPH_AW-1:0]};
      rd_glyph = 1'b1;
    end
  end

  lcd_char_store #(
    .AW(TEXT_AW), .GAW(GLYPH_AW), .DW(DW), .FILL(8'h20)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(dwr), .wglyph_i(glyph_q), .waddr_i(ac_q), .wdata_i(wdata_i),
    .clear_i(cmd && op == OP_CLEAR),
    .rglyph_i(rd_glyph), .raddr_i(rd_addr), .rdata_o(ram_rd)
  );

  always_comb begin
    status_word                = '0;
    status_word[TEXT_AW-1:0]   = ac_q;
    status_word[DW-1]          = busy_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q    <= '0;
      glyph_q <= 1'b0;
      id_q    <= 1'b1;
      sh_q    <= 1'b0;
      disp_o  <= '0;
      func_o  <= 3'b100;
      shift_o <= '0;
      out_q   <= '0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= reject;
      if (status_rd) rdata_o <= status_word;
      if (drd) begin
        rdata_o <= out_q;
        ac_q    <= ac_nxt;
        out_q   <= ram_rd;
      end
      if (dwr) begin
        ac_q <= ac_nxt;
        if (!glyph_q && sh_q) shift_o <= shift_step(shift_o, id_q, func_o[1]);
      end
      if (cmd) begin
        unique case (op)
          OP_TADDR: begin
            ac_q    <= wdata_i[TEXT_AW-1:0];
            glyph_q <= 1'b0;
            out_q   <= ram_rd;
          end
          OP_GADDR: begin
            ac_q    <= {{(TEXT_AW-GLYPH_AW){1'b0}}, wdata_i[GLYPH_AW-1:0]};
            glyph_q <= 1'b1;
            out_q   <= ram_rd;
          end
          OP_FUNC: func_o <= wdata_i[4:2];
          OP_SHIFT: begin
            if (wdata_i[3]) begin
              shift_o <= shift_step(shift_o, !wdata_i[2], func_o[1]);
            end else begin
              ac_q  <= ac_nxt;
              out_q <= ram_rd;
            end
          end
          OP_DISP: disp_o <= wdata_i[2:0];
          OP_ENTRY: begin
            id_q <= wdata_i[1];
            sh_q <= wdata_i[0];
          end
          OP_HOME: begin
            ac_q    <= '0;
            glyph_q <= 1'b0;
            shift_o <= '0;
          end
          OP_CLEAR: begin
            ac_q    <= '0;
            glyph_q <= 1'b0;
            id_q    <= 1'b1;
            shift_o <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_instr_core_chk.sv
module lcd_instr_core_chk #(
  parameter int LINE_LEN = 40,
  parameter int SW       = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          sel_i,
  input logic          rd_i,
  input logic [7:0]    wdata_i,
  input logic          busy_o,
  input logic          err_o,
  input logic [2:0]    disp_o,
  input logic [2:0]    func_o,
  input logic [SW-1:0] shift_o
);
  logic stat, acc_cmd;
  assign stat    = req_i && !sel_i && rd_i;
  assign acc_cmd = req_i && !busy_o && !sel_i && !rd_i;

  p_busy_after_accept_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && !stat) |=> busy_o);

  p_reject_flag_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy_o && !stat) |=> err_o);

  p_err_cause_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i && busy_o && (sel_i || !rd_i)));

  p_reject_holds_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy_o && !stat) |=> ($stable(disp_o) && $stable(func_o) && $stable(shift_o)));

  p_status_no_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat && !busy_o) |=> !busy_o);

  p_clear_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_cmd && wdata_i == 8'h01) |=> (shift_o == '0));

  p_home_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_cmd && wdata_i[7:1] == 7'b0000001) |=> (shift_o == '0));

  p_disp_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_cmd && wdata_i[7:3] == 5'b00001) |=> (disp_o == $past(wdata_i[2:0])));

  p_shift_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o < SW'(2 * LINE_LEN));
endmodule

bind lcd_instr_core lcd_instr_core_chk #(.LINE_LEN(LINE_LEN), .SW(SW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .sel_i(sel_i), .rd_i(rd_i),
  .wdata_i(wdata_i[7:0]), .busy_o(busy_o), .err_o(err_o), .disp_o(disp_o),
  .func_o(func_o), .shift_o(shift_o)
);

// File: tb/lcd_instr_core_tb.sv
module lcd_instr_core_tb;
  localparam int NV = 44;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, sel_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       busy_o, err_o;
  logic [2:0] disp_o, func_o;
  logic [6:0] shift_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  lcd_instr_core #(.BUSY_CYC(3)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .sel_i(sel_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .busy_o(busy_o), .err_o(err_o),
    .disp_o(disp_o), .func_o(func_o), .shift_o(shift_o)
  );

  // {check, sel, rd, byte, expected rdata}
  localparam logic [18:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,8'h38,8'h00},  // two-line
    {1'b0,1'b0,1'b0,8'h06,8'h00},  // increment
    {1'b0,1'b0,1'b0,8'h80,8'h00},
    {1'b0,1'b1,1'b0,8'h41,8'h00},
    {1'b0,1'b1,1'b0,8'h42,8'h00},
    {1'b1,1'b0,1'b1,8'h00,8'h02},  // R6 step up
    {1'b1,1'b1,1'b1,8'h00,8'h20},  // R11 stale after writes
    {1'b0,1'b0,1'b0,8'h80,8'h00},
    {1'b1,1'b1,1'b1,8'h00,8'h41},  // R5 R11
    {1'b1,1'b1,1'b1,8'h00,8'h42},
    {1'b0,1'b0,1'b0,8'hA7,8'h00},
    {1'b0,1'b1,1'b0,8'h43,8'h00},
    {1'b1,1'b0,1'b1,8'h00,8'h40},  // R7 0x27 up
    {1'b0,1'b0,1'b0,8'h10,8'h00},
    {1'b1,1'b0,1'b1,8'h00,8'h27},  // R7 R9 0x40 down
    {1'b1,1'b1,1'b1,8'h00,8'h43},  // R11 loaded by cursor step
    {1'b0,1'b0,1'b0,8'h04,8'h00},
    {1'b0,1'b0,1'b0,8'h80,8'h00},
    {1'b1,1'b1,1'b1,8'h00,8'h41},
    {1'b1,1'b0,1'b1,8'h00,8'h67},  // R7 0x00 down
    {1'b0,1'b0,1'b0,8'h06,8'h00},
    {1'b0,1'b0,1'b0,8'h14,8'h00},
    {1'b1,1'b0,1'b1,8'h00,8'h00},  // R7 0x67 up
    {1'b0,1'b0,1'b0,8'h7F,8'h00},
    {1'b0,1'b1,1'b0,8'h15,8'h00},
    {1'b1,1'b0,1'b1,8'h00,8'h00},  // R8 glyph wrap
    {1'b0,1'b0,1'b0,8'h7F,8'h00},
    {1'b1,1'b1,1'b1,8'h00,8'h15},  // R5 glyph select
    {1'b1,1'b0,1'b1,8'h00,8'h00},
    {1'b0,1'b0,1'b0,8'h30,8'h00},  // one-line
    {1'b0,1'b0,1'b0,8'hCF,8'h00},
    {1'b0,1'b1,1'b0,8'h44,8'h00},
    {1'b1,1'b0,1'b1,8'h00,8'h00},  // R8 0x4F up
    {1'b0,1'b0,1'b0,8'h04,8'h00},
    {1'b0,1'b0,1'b0,8'h80,8'h00},
    {1'b0,1'b0,1'b0,8'h10,8'h00},
    {1'b1,1'b0,1'b1,8'h00,8'h4F},  // R8 0x00 down
    {1'b1,1'b1,1'b1,8'h00,8'h44},
    {1'b1,1'b0,1'b1,8'h00,8'h4E},  // R6 step down
    {1'b0,1'b0,1'b0,8'h01,8'h00},
    {1'b0,1'b0,1'b0,8'h80,8'h00},
    {1'b1,1'b1,1'b1,8'h00,8'h20},  // R3 cleared
    {1'b1,1'b1,1'b1,8'h00,8'h20},
    {1'b1,1'b0,1'b1,8'h00,8'h02}   // R3 increment forced
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // caller is at a falling edge; returns at the next falling edge
  task automatic xact(input logic s, input logic r, input logic [7:0] d);
    sel_i = s; rd_i = r; wdata_i = d; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic cmd(input logic [7:0] d);
    xact(1'b0, 1'b0, d); wait_idle();
  endtask

  task automatic wr(input logic [7:0] d);
    xact(1'b1, 1'b0, d); wait_idle();
  endtask

  task automatic status(input string req, input int exp);
    xact(1'b0, 1'b1, 8'h00); chk(req, rdata_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 rdata", rdata_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 disp", disp_o, 0);
    chk("R1 func", func_o, 3'b100);
    chk("R1 shift", shift_o, 0);
    status("R1 ac", 8'h00);

    for (int i = 0; i < NV; i++) begin
      xact(VEC[i][17], VEC[i][16], VEC[i][15:8]);
      if (VEC[i][18]) chk($sformatf("R5-table vec %0d", i), rdata_o, VEC[i][7:0]);
      wait_idle();
    end

    // R2 display and function bits
    cmd(8'h0F); chk("R2 disp all", disp_o, 3'b111);
    cmd(8'h0A); chk("R2 disp cursor", disp_o, 3'b010);
    cmd(8'h3C); chk("R2 func", func_o, 3'b111);
    cmd(8'h38); chk("R2 func two", func_o, 3'b110);

    // R9 display shift, two-line modulo 40
    cmd(8'h83);
    cmd(8'h18); chk("R9 left", shift_o, 1);
    status("R9 ac kept", 8'h03);
    cmd(8'h1C); chk("R9 right", shift_o, 0);
    cmd(8'h1C); chk("R9 wrap right", shift_o, 39);
    cmd(8'h18); chk("R9 wrap left", shift_o, 0);

    // R4 home
    cmd(8'h85); wr(8'h55);
    cmd(8'h18);
    cmd(8'h02); chk("R4 shift", shift_o, 0);
    status("R4 ac", 8'h00);
    cmd(8'h85);
    xact(1'b1, 1'b1, 8'h00); chk("R4 ram kept", rdata_o, 8'h55); wait_idle();

    // R10 auto shift
    cmd(8'h07); cmd(8'h80);
    wr(8'h61); chk("R10 left on write", shift_o, 1);
    cmd(8'h05);
    wr(8'h62); chk("R10 right on write", shift_o, 0);
    cmd(8'h40);
    wr(8'h63); chk("R10 glyph no shift", shift_o, 0);
    cmd(8'h80);
    xact(1'b1, 1'b1, 8'h00); chk("R10 read no shift", shift_o, 0); wait_idle();
    cmd(8'h06);

    // R12 busy window and refusal
    xact(1'b0, 1'b0, 8'h0F);
    chk("R12 busy set", busy_o, 1);
    xact(1'b0, 1'b0, 8'h08);
    chk("R12 err pulse", err_o, 1);
    chk("R12 ignored", disp_o, 3'b111);
    xact(1'b0, 1'b1, 8'h00);
    chk("R12 status busy bit", rdata_o[7], 1);
    chk("R12 status no err", err_o, 0);
    wait_idle();
    xact(1'b0, 1'b0, 8'h0C);
    n = 0;
    while (busy_o) begin n++; @(negedge clk_i); end
    chk("R12 busy length", n, 3);
    chk("R12 accepted after idle", disp_o, 3'b100);
    chk("R12 err clear", err_o, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule